// File: doc/BRIEF.md
# Muxed-Bus Asynchronous Flash Read Sequencer

This block is the host side of a single-word asynchronous read from a flash device whose address and data share one bus. A user asks for a word through a valid/ready port. The sequencer then runs the device pins through a fixed order. It drops chip-enable and the address strobe together and drives the address onto the shared bus. It raises the strobe so the device latches the address, and keeps the address on the bus for a hold time. It then stops driving the bus and enables the device output. It samples the word once every access limit is met. Last, it drops output-enable and chip-enable together and waits for the device to let go of the bus.

Every phase length is a clock count. Each count is worked out at elaboration by rounding a nanosecond limit up to whole clock periods, so the same code fits any system clock. The captured word comes back as a one-cycle pulse on the user side. A new request is taken only when the sequencer is idle and the minimum read-cycle spacing has passed. The write strobe is held inactive. The first strobe after reset waits for the write-to-strobe recovery time.

Top module: `mflash_rd_seq`

## Requirements
- R1: While reset is held, chip-enable, address strobe, output-enable and write strobe are high (inactive), the host does not drive the bus, and both req_ready and rd_valid are low.
- R2: Chip-enable is low in every cycle in which the address strobe is low.
- R3: The address strobe stays low for at least max(ceil(12 ns/T), ceil(5 ns/T)) cycles. Throughout that time the host drives the accepted address on the bus (fb_ad_oe high, fb_ad_o equal to req_addr).
- R4: After the strobe rises, the host keeps driving the same address for at least ceil(6 ns/T) cycles.
- R5: The host stops driving the bus at least one cycle before output-enable falls, and does not drive it while output-enable is low. Output-enable falls only while the strobe is high, and no sooner than ceil(10 ns/T) cycles after the address was first driven.
- R6: The word returned on rd_data is the one the device presents after chip-enable has been low for at least ceil(76 ns/T) cycles and output-enable for at least ceil(20 ns/T) cycles, counting the sampling cycle.
- R7: Output-enable and chip-enable rise in the same cycle. For ceil(15 ns/T) cycles after that, counting that cycle, the host neither drives the bus nor lowers chip-enable.
- R8: Two successive falling edges of the address strobe are at least ceil(76 ns/T) cycles apart.
- R9: The write strobe stays high at all times, and the first strobe fall after reset comes no sooner than ceil(15 ns/T) cycles after reset release.
- R10: req_ready is high only while all device pins are inactive and the bus is released. A request made while busy is ignored. Each accepted request yields exactly one single-cycle rd_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | BUS_W | Word address of the request |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds the returned word |
| rd_data | output | BUS_W | Captured word |
| fb_ce_n | output | 1 | Device chip-enable, active low |
| fb_avd_n | output | 1 | Address strobe, active low, latched on rising edge |
| fb_oe_n | output | 1 | Device output-enable, active low |
| fb_we_n | output | 1 | Device write strobe, held high |
| fb_ad_o | output | BUS_W | Value the host drives on the shared bus |
| fb_ad_oe | output | 1 | Host drive enable for the shared bus |
| fb_ad_i | input | BUS_W | Value seen on the shared bus |

## Verification
The checker assumes that reset is held long enough for every register to settle. It also assumes that the phase counts come from the default clock, so that one cycle of address hold and a read-cycle spacing below its counter's range are enough. It makes no assumption about the returned data. In the bench, a device model on the pins counts how long chip-enable and output-enable have been low, and it puts the correct word on the bus only once both access limits have passed; before that it puts its complement. Requests go through the handshake. The one deliberate exception is a burst of requests raised while the sequencer is busy and withdrawn before it turns idle, which exercises the ignore rule.

// File: rtl/mflash_pkg.sv
package mflash_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_TURN,
        ST_READ,
        ST_REL
    } seq_st_e;

    function automatic int ns2cyc(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mflash_sat_cnt.sv
module mflash_sat_cnt #(
    parameter int LIMIT    = 1,
    parameter bit RST_FULL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic done_o
);
    localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i && (cnt_q != TOP)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_FULL ? TOP : '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == TOP);

endmodule

// File: rtl/mflash_capture.sv
module mflash_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take_i,
    input  logic [W-1:0] ad_i,
    output logic         vld_o,
    output logic [W-1:0] data_o
);
    logic         vld_d, vld_q;
    logic [W-1:0] data_d, data_q;

    always_comb begin
        vld_d  = take_i;
        data_d = take_i ? ad_i : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            data_q <= '0;
        end else begin
            vld_q  <= vld_d;
            data_q <= data_d;
        end
    end

    assign vld_o  = vld_q;
    assign data_o = data_q;

endmodule

// File: rtl/mflash_rd_seq.sv
module mflash_rd_seq
    import mflash_pkg::*;
#(
    parameter int BUS_W     = 16,
    parameter int CLK_NS    = 8,
    parameter int T_CE_NS   = 76,
    parameter int T_AA_NS   = 76,
    parameter int T_ACC_NS  = 76,
    parameter int T_RC_NS   = 76,
    parameter int T_AVDP_NS = 12,
    parameter int T_AS_NS   = 5,
    parameter int T_AH_NS   = 6,
    parameter int T_OE_NS   = 20,
    parameter int T_OEZ_NS  = 15,
    parameter int T_ASO_NS  = 10,
    parameter int T_WEA_NS  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BUS_W-1:0] req_addr,
    output logic             rd_valid,
    output logic [BUS_W-1:0] rd_data,
    output logic             fb_ce_n,
    output logic             fb_avd_n,
    output logic             fb_oe_n,
    output logic             fb_we_n,
    output logic [BUS_W-1:0] fb_ad_o,
    output logic             fb_ad_oe,
    input  logic [BUS_W-1:0] fb_ad_i
);
    // phase lengths in clock cycles, rounded up
    localparam int N_AVDL = imax(imax(ns2cyc(T_AVDP_NS, CLK_NS), ns2cyc(T_AS_NS, CLK_NS)), 1);
    localparam int N_AH   = imax(ns2cyc(T_AH_NS, CLK_NS), 1);
    localparam int N_ASO  = ns2cyc(T_ASO_NS, CLK_NS);
    localparam int N_TURN = imax(N_ASO - N_AVDL - N_AH, 1);
    localparam int N_OE   = imax(ns2cyc(T_OE_NS, CLK_NS), 1);
    localparam int N_ACC  = imax(ns2cyc(imax(imax(T_CE_NS, T_AA_NS), T_ACC_NS), CLK_NS), 1);
    localparam int N_RC   = imax(ns2cyc(T_RC_NS, CLK_NS), 1);
    localparam int N_REL  = imax(ns2cyc(T_OEZ_NS, CLK_NS), 1);
    localparam int N_WEA  = imax(ns2cyc(T_WEA_NS, CLK_NS), 1);
    localparam int PH_MAX = imax(imax(N_AVDL, N_AH), imax(N_TURN, N_REL));
    localparam int PH_W   = $clog2(PH_MAX + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [PH_W-1:0]  ph;
        logic [BUS_W-1:0] addr;
        logic             ce_n;
        logic             avd_n;
        logic             oe_n;
        logic             ad_oe;
    } seq_s;

    seq_s s_d, s_q;
    logic ready;
    logic accept;
    logic take;
    logic guard_done;
    logic gap_done;
    logic ce_done;
    logic oe_done;

    // write-recovery guard after reset
    mflash_sat_cnt #(.LIMIT(N_WEA - 1), .RST_FULL(1'b0)) u_guard (
        .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .en_i(1'b1), .done_o(guard_done)
    );

    // read-cycle spacing, counted from each accepted request
    mflash_sat_cnt #(.LIMIT(N_RC - 1), .RST_FULL(1'b1)) u_gap (
        .clk(clk), .rst_n(rst_n), .clr_i(accept), .en_i(1'b1), .done_o(gap_done)
    );

    // access time from chip-enable / strobe / address
    mflash_sat_cnt #(.LIMIT(N_ACC - 1), .RST_FULL(1'b0)) u_ce_age (
        .clk(clk), .rst_n(rst_n), .clr_i(s_q.ce_n), .en_i(!s_q.ce_n), .done_o(ce_done)
    );

    // access time from output-enable
    mflash_sat_cnt #(.LIMIT(N_OE - 1), .RST_FULL(1'b0)) u_oe_age (
        .clk(clk), .rst_n(rst_n), .clr_i(s_q.oe_n), .en_i(!s_q.oe_n), .done_o(oe_done)
    );

    mflash_capture #(.W(BUS_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .take_i(take), .ad_i(fb_ad_i),
        .vld_o(rd_valid), .data_o(rd_data)
    );

    assign ready = (s_q.st == ST_IDLE) && guard_done && gap_done;

    always_comb begin
        s_d    = s_q;
        accept = 1'b0;
        take   = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid && ready) begin
                    accept     = 1'b1;
                    s_d.st     = ST_ADDR;
                    s_d.ph     = PH_W'(N_AVDL - 1);
                    s_d.addr   = req_addr;
                    s_d.ce_n   = 1'b0;
                    s_d.avd_n  = 1'b0;
                    s_d.ad_oe  = 1'b1;
                end
            end
            ST_ADDR: begin
                if (s_q.ph == '0) begin
                    s_d.st    = ST_HOLD;
                    s_d.ph    = PH_W'(N_AH - 1);
                    s_d.avd_n = 1'b1;
                end else begin
                    s_d.ph = s_q.ph - 1'b1;
                end
            end
            ST_HOLD: begin
                if (s_q.ph == '0) begin
                    s_d.st    = ST_TURN;
                    s_d.ph    = PH_W'(N_TURN - 1);
                    s_d.ad_oe = 1'b0;
                end else begin
                    s_d.ph = s_q.ph - 1'b1;
                end
            end
            ST_TURN: begin
                if (s_q.ph == '0) begin
                    s_d.st   = ST_READ;
                    s_d.oe_n = 1'b0;
                end else begin
                    s_d.ph = s_q.ph - 1'b1;
                end
            end
            ST_READ: begin
                if (ce_done && oe_done) begin
                    take     = 1'b1;
                    s_d.st   = ST_REL;
                    s_d.ph   = PH_W'(N_REL - 1);
                    s_d.ce_n = 1'b1;
                    s_d.oe_n = 1'b1;
                end
            end
            ST_REL: begin
                if (s_q.ph == '0) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.ph = s_q.ph - 1'b1;
                end
            end
            default: begin
                s_d.st    = ST_IDLE;
                s_d.ce_n  = 1'b1;
                s_d.avd_n = 1'b1;
                s_d.oe_n  = 1'b1;
                s_d.ad_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, ph: '0, addr: '0, ce_n: 1'b1,
                     avd_n: 1'b1, oe_n: 1'b1, ad_oe: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = ready;
    assign fb_ce_n   = s_q.ce_n;
    assign fb_avd_n  = s_q.avd_n;
    assign fb_oe_n   = s_q.oe_n;
    assign fb_we_n   = 1'b1;
    assign fb_ad_o   = s_q.addr;
    assign fb_ad_oe  = s_q.ad_oe;

endmodule

// File: rtl/mflash_rd_seq_chk.sv
module mflash_rd_seq_chk #(
    parameter int N_AVDL = 2,
    parameter int N_RC   = 10
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic avd_n,
    input logic oe_n,
    input logic ad_oe,
    input logic req_ready,
    input logic rd_valid
);
    logic        avd_prev, oe_prev;
    logic [15:0] avd_run;
    logic [15:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            avd_prev <= 1'b1;
            oe_prev  <= 1'b1;
            avd_run  <= '0;
            gap      <= 16'hFFFF;
        end else begin
            avd_prev <= avd_n;
            oe_prev  <= oe_n;
            if (!avd_n) begin
                if (avd_run != 16'hFFFF) avd_run <= avd_run + 1'b1;
            end else begin
                avd_run <= '0;
            end
            if (!avd_n && avd_prev) gap <= 16'd1;
            else if (gap != 16'hFFFF) gap <= gap + 1'b1;
        end
    end

    p_ce_covers_avd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !avd_n |-> !ce_n);
    p_avd_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (avd_n && !avd_prev) |-> (int'(avd_run) >= N_AVDL));
    p_addr_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !avd_n |-> ad_oe);
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (avd_n && !avd_prev) |-> ad_oe);
    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !ad_oe);
    p_oe_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> avd_n);
    p_release_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && !oe_prev) |-> ce_n);
    p_no_drive_after_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && !oe_prev) |=> !ad_oe);
    p_cycle_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!avd_n && avd_prev) |-> (int'(gap) >= N_RC));
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ce_n && oe_n && !ad_oe));

endmodule

bind mflash_rd_seq mflash_rd_seq_chk #(.N_AVDL(N_AVDL), .N_RC(N_RC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(fb_ce_n), .avd_n(fb_avd_n), .oe_n(fb_oe_n),
    .ad_oe(fb_ad_oe), .req_ready(req_ready), .rd_valid(rd_valid)
);

// File: tb/mflash_rd_seq_test.sv
module mflash_rd_seq_test;
    localparam int P = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        fb_ce_n, fb_avd_n, fb_oe_n, fb_we_n, fb_ad_oe;
    logic [15:0] fb_ad_o;
    logic [15:0] fb_ad_i = '0;

    always #4 clk = ~clk;

    mflash_rd_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .fb_ce_n(fb_ce_n), .fb_avd_n(fb_avd_n), .fb_oe_n(fb_oe_n), .fb_we_n(fb_we_n),
        .fb_ad_o(fb_ad_o), .fb_ad_oe(fb_ad_oe), .fb_ad_i(fb_ad_i)
    );

    function automatic int cdiv(input int ns);
        return (ns + P - 1) / P;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    function automatic logic [15:0] word_of(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    int e_avdl, e_ah, e_aso, e_acc, e_oe, e_rc, e_rel, e_wea;
    int total = 0, bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // device model: correct word only after both access limits
    int dv_ce = 0, dv_oe = 0;
    logic [15:0] dv_lat = '0;
    logic dv_avd_prev = 1'b1;
    always @(negedge clk) begin
        int c, o;
        logic [15:0] l;
        c = fb_ce_n ? 0 : dv_ce + 1;
        o = fb_oe_n ? 0 : dv_oe + 1;
        l = (fb_avd_n && !dv_avd_prev) ? fb_ad_o : dv_lat;
        dv_ce <= c;
        dv_oe <= o;
        dv_lat <= l;
        dv_avd_prev <= fb_avd_n;
        fb_ad_i <= (c * P >= 76 && o * P >= 20) ? word_of(l) : ~word_of(l);
    end

    // pin-level monitor
    int cyc = 0, avd_run = 0, hold_run = 0, ce_age = 0, rel_left = 0;
    int last_fall = -1, falls = 0, accepts = 0, reads = 0;
    bit in_hold = 1'b0, prev_avd = 1'b1, prev_oe = 1'b1, prev_adoe = 1'b0, prev_vld = 1'b0;
    logic [15:0] exp_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk(fb_we_n == 1'b1, "R9 we_n", fb_we_n, 1);
            if (!fb_avd_n && prev_avd) begin
                if (falls == 0) chk(cyc >= e_wea, "R9 first strobe", cyc, e_wea);
                else chk(cyc - last_fall >= e_rc, "R8 spacing", cyc - last_fall, e_rc);
                last_fall = cyc;
                falls++;
            end
            if (!fb_avd_n) begin
                avd_run++;
                chk(!fb_ce_n, "R2 ce under strobe", fb_ce_n, 0);
                chk(fb_ad_oe && fb_ad_o == exp_addr, "R3 addr drive", fb_ad_o, exp_addr);
            end
            if (fb_avd_n && !prev_avd) begin
                chk(avd_run >= e_avdl, "R3 strobe width", avd_run, e_avdl);
                avd_run = 0;
                in_hold = 1'b1;
                hold_run = 0;
            end
            if (in_hold) begin
                if (fb_ad_oe && fb_ad_o == exp_addr) hold_run++;
                else begin
                    chk(hold_run >= e_ah, "R4 addr hold", hold_run, e_ah);
                    in_hold = 1'b0;
                end
            end
            if (!fb_oe_n && prev_oe) begin
                chk(fb_avd_n && !prev_adoe, "R5 turnaround", {fb_avd_n, prev_adoe}, 2);
                chk(ce_age >= e_aso, "R5 addr to oe", ce_age, e_aso);
            end
            if (!fb_oe_n) chk(!fb_ad_oe, "R5 contention", fb_ad_oe, 0);
            if (fb_oe_n && !prev_oe) begin
                chk(fb_ce_n, "R7 joint release", fb_ce_n, 1);
                rel_left = e_rel;
            end
            if (rel_left > 0) begin
                chk(!fb_ad_oe && fb_ce_n, "R7 release wait", {fb_ad_oe, fb_ce_n}, 1);
                rel_left--;
            end
            if (rd_valid) begin
                chk(!prev_vld, "R10 pulse width", prev_vld, 0);
                chk(rd_data == word_of(exp_addr), "R6 data", rd_data, word_of(exp_addr));
                reads++;
            end
            if (req_valid && req_ready) begin
                chk(fb_ce_n && fb_oe_n && !fb_ad_oe, "R10 ready idle", {fb_ce_n, fb_oe_n, fb_ad_oe}, 6);
                exp_addr = req_addr;
                accepts++;
            end
            ce_age = fb_ce_n ? 0 : ce_age + 1;
            prev_avd = fb_avd_n;
            prev_oe = fb_oe_n;
            prev_adoe = fb_ad_oe;
            prev_vld = rd_valid;
            cyc++;
        end
    end

    task automatic issue(input logic [15:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        e_avdl = mx(cdiv(12), cdiv(5));
        e_ah = mx(cdiv(6), 1);
        e_aso = cdiv(10);
        e_acc = cdiv(76);
        e_oe = cdiv(20);
        e_rc = cdiv(76);
        e_rel = cdiv(15);
        e_wea = cdiv(15);

        repeat (4) @(negedge clk);
        // R1 reset state
        chk(fb_ce_n && fb_avd_n && fb_oe_n && fb_we_n, "R1 pins idle",
            {fb_ce_n, fb_avd_n, fb_oe_n, fb_we_n}, 15);
        chk(!fb_ad_oe, "R1 bus released", fb_ad_oe, 0);
        chk(!req_ready && !rd_valid, "R1 handshake low", {req_ready, rd_valid}, 0);
        req_valid = 1'b1;
        req_addr = 16'h1234;
        rst_n = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;

        // walking ones and corners
        for (int i = 0; i < 16; i++) issue(16'h1 << i);
        issue(16'h0000);
        issue(16'hFFFF);
        // sequential with idle gaps
        for (int i = 0; i < 48; i++) begin
            repeat (i % 4) @(negedge clk);
            issue(16'(i * 16'h0301 + 16'h00F0));
        end

        // R10: requests while busy are ignored
        issue(16'hBEEF);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = 16'h0BAD;
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        repeat (40) @(negedge clk);
        chk(falls == accepts, "R10 busy ignored", falls, accepts);
        chk(reads == accepts, "R10 one pulse per request", reads, accepts);
        chk(rd_data == word_of(16'hBEEF), "R10 busy addr unused", rd_data, word_of(16'hBEEF));
        chk(accepts == 68, "R10 accepted count", accepts, 68);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", accepts, 68);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule